// File: doc/BRIEF.md
# Real-Mode Address Translation Unit

This block resolves memory accesses made while relocation is switched off. Each request carries a 64-bit effective address, an access kind (load, store or fetch), the instruction and data relocation enables, a hypervisor-state bit and a flag that says whether a hypervisor mode exists at all. For one accepted request the block returns one registered response. The response is one of the following: a real address, an instruction or data storage fault with a status code, a machine check, a handoff to the virtualised-real-mode (paged) path, or a notice that relocation is on, so the request belongs to the normal translation path.

Three configuration registers are written through a simple select/data port. They are a partition control word, a hypervisor offset and a bounded-area offset. The control word holds a 4-bit size code, and the block keeps a decoded limit register that is refreshed whenever that word is written and at reset. Requests and responses use valid/ready handshakes.

Top module: `rmode_xlate`

## Requirements
- R1: A fetch (kind 2) is handled in real mode only when `req_ir` is 0, and a load (kind 0) or store (kind 1) only when `req_dr` is 0. In any other case the result is 5 (relocation on), with address, status and fault address all zero.
- R2: The base real address is the effective address with bits 63..60 forced to zero.
- R3: When `req_hv` is 1 or `req_hv_present` is 0, the result is 0 (real address). The hypervisor offset (config select 1) is ORed into the base only when effective-address bit 63 is 0.
- R4: Outside R3, when control bit 0 (virtual real mode enable) is 1, control bit 1 picks the outcome. If bit 1 is 1, the result is 4 (handoff) with the base as address. If bit 1 is 0, the result is 3 (machine check) with status 0.
- R5: Outside R3 and R4, a base below the decoded limit gives result 0, and the address is the base ORed with the bounded-area offset (config select 2).
- R6: Outside R3 and R4, a base at or above the limit raises a fault. A fetch gives result 1 with status 0x08000000. A load gives result 2 with status 0x08000000. A store gives result 2 with status 0x0A000000. Only result 2 puts the effective address on `rsp_fault_ea`, which is zero otherwise.
- R7: The size code sits in control bits 11..8. Code 0x1 decodes to 16 GB, 0x2 to 1 GB, 0x3 to 64 MB, 0x4 to 256 MB, 0x7 to 128 MB and 0x8 to 32 MB. Every other code decodes to a limit of zero, so every bounded access faults.
- R8: The limit is recomputed on each control write (config select 0) and at reset. Reset loads the control word with code 0x1 and both enable bits 0.
- R9: `req_ready` is 1 exactly when no response is held or `rsp_ready` is 1. The response appears in the cycle after acceptance and stays unchanged while it is stalled.
- R10: A configuration write in the same cycle as an accepted request affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 hypervisor offset, 2 bounded-area offset |
| cfg_wdata | input | 64 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_ea | input | 64 | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_ir | input | 1 | Instruction relocation enable |
| req_dr | input | 1 | Data relocation enable |
| req_hv | input | 1 | Hypervisor state |
| req_hv_present | input | 1 | A hypervisor mode exists |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_result | output | 3 | 0 real, 1 instruction fault, 2 data fault, 3 machine check, 4 handoff, 5 relocation on |
| rsp_addr | output | 64 | Real address (results 0 and 4) |
| rsp_status | output | 32 | Fault status code |
| rsp_fault_ea | output | 64 | Faulting effective address for data faults |

## Verification
The assertions assume that `req_kind` never carries the unused code 3 and that the requester keeps its request steady while `req_ready` is low. They also assume that `rsp_ready` is only dropped while a response is held. The directed stimulus only issues kinds 0 to 2. It changes request fields only at falling edges, after an acceptance or while the request is idle. It drops `rsp_ready` in the single stall scenario and raises it again before any further traffic.

// File: rtl/rmode_pkg.sv
// Shared types and codes for the real-mode translation unit.
// Assumes a 64-bit effective address and 32-bit status codes.
package rmode_pkg;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        RES_REAL   = 3'd0,
        RES_IFAULT = 3'd1,
        RES_DFAULT = 3'd2,
        RES_MCHECK = 3'd3,
        RES_HANDOFF= 3'd4,
        RES_RELOC  = 3'd5
    } result_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_HVOFS = 2'd1;
    localparam logic [1:0] SEL_RMOFS = 2'd2;

    localparam int CTRL_VRM_BIT  = 0;
    localparam int CTRL_DESC_BIT = 1;
    localparam int CTRL_CODE_LSB = 8;

    localparam logic [31:0] STAT_BOUND = 32'h0800_0000;
    localparam logic [31:0] STAT_WRITE = 32'h0200_0000;

endpackage

// File: rtl/rmode_limit_dec.sv
// Decodes the 4-bit size code into a byte limit for the bounded area.
// Assumes ADDR_W is at least 35 so the largest limit fits.
module rmode_limit_dec #(
    parameter int ADDR_W = 64,
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] limit
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    // Map each supported code to its power-of-two size, else zero.
    always_comb begin
        case (code)
            4'h8:    limit = ONE << 25;
            4'h3:    limit = ONE << 26;
            4'h7:    limit = ONE << 27;
            4'h4:    limit = ONE << 28;
            4'h2:    limit = ONE << 30;
            4'h1:    limit = ONE << 34;
            default: limit = '0;
        endcase
    end
endmodule

// File: rtl/rmode_route.sv
// Combinational classification of one request into a response.
// Assumes kind is never 3 and the limit is already decoded.
module rmode_route
    import rmode_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int STAT_W   = 32,
    parameter int CLR_BITS = 4
) (
    input  logic [ADDR_W-1:0] ea,
    input  kind_e             kind,
    input  logic              ir,
    input  logic              dr,
    input  logic              hv,
    input  logic              hv_present,
    input  logic              vrm_en,
    input  logic              desc_ok,
    input  logic [ADDR_W-1:0] limit,
    input  logic [ADDR_W-1:0] hv_ofs,
    input  logic [ADDR_W-1:0] rm_ofs,
    output result_e           result,
    output logic [ADDR_W-1:0] addr,
    output logic [STAT_W-1:0] status,
    output logic [ADDR_W-1:0] fault_ea
);
    localparam logic [ADDR_W-1:0] BASE_MASK =
        {{CLR_BITS{1'b0}}, {(ADDR_W-CLR_BITS){1'b1}}};

    logic              real_mode;
    logic [ADDR_W-1:0] base;

    // Decide whether relocation is off for this access kind.
    always_comb real_mode = (kind == KIND_FETCH) ? !ir : !dr;

    // Strip the top effective-address bits to form the base.
    always_comb base = ea & BASE_MASK;

    // Pick hypervisor offset, handoff, bounded area or fault.
    always_comb begin
        result   = RES_RELOC;
        addr     = '0;
        status   = '0;
        fault_ea = '0;
        if (real_mode) begin
            if (hv || !hv_present) begin
                result = RES_REAL;
                addr   = ea[ADDR_W-1] ? base : (base | hv_ofs);
            end else if (vrm_en) begin
                if (desc_ok) begin
                    result = RES_HANDOFF;
                    addr   = base;
                end else begin
                    result = RES_MCHECK;
                end
            end else if (base < limit) begin
                result = RES_REAL;
                addr   = base | rm_ofs;
            end else if (kind == KIND_FETCH) begin
                result = RES_IFAULT;
                status = STAT_BOUND;
            end else begin
                result   = RES_DFAULT;
                status   = (kind == KIND_STORE) ? (STAT_BOUND | STAT_WRITE) : STAT_BOUND;
                fault_ea = ea;
            end
        end
    end
endmodule

// File: rtl/rmode_xlate.sv
// Real-mode translation unit: configuration registers, decoded limit,
// request/response handshake and one registered response stage.
// Assumes the requester holds its request while req_ready is low.
module rmode_xlate
    import rmode_pkg::*;
#(
    parameter int          ADDR_W     = 64,
    parameter int          STAT_W     = 32,
    parameter int          CODE_W     = 4,
    parameter logic [63:0] CTRL_RESET = 64'h0000_0000_0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_ea,
    input  logic [1:0]        req_kind,
    input  logic              req_ir,
    input  logic              req_dr,
    input  logic              req_hv,
    input  logic              req_hv_present,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [2:0]        rsp_result,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [STAT_W-1:0] rsp_status,
    output logic [ADDR_W-1:0] rsp_fault_ea
);
    localparam logic [ADDR_W-1:0] CTRL_RST = CTRL_RESET[ADDR_W-1:0];

    logic [ADDR_W-1:0] ctrl_q, hv_ofs_q, rm_ofs_q, limit_q;
    logic [ADDR_W-1:0] wr_limit, rst_limit;
    logic [CODE_W-1:0] wr_code;
    result_e           nx_result;
    logic [ADDR_W-1:0] nx_addr, nx_fault_ea;
    logic [STAT_W-1:0] nx_status;
    logic              accept;

    // Size code carried by the incoming control write.
    always_comb wr_code = cfg_wdata[CTRL_CODE_LSB +: CODE_W];

    rmode_limit_dec #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_dec_wr (
        .code  (wr_code),
        .limit (wr_limit)
    );

    rmode_limit_dec #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_dec_rst (
        .code  (CTRL_RST[CTRL_CODE_LSB +: CODE_W]),
        .limit (rst_limit)
    );

    // Hold configuration and refresh the limit on control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_RST;
            limit_q  <= rst_limit;
            hv_ofs_q <= '0;
            rm_ofs_q <= '0;
        end else if (cfg_wr) begin
            case (cfg_sel)
                SEL_CTRL: begin
                    ctrl_q  <= cfg_wdata;
                    limit_q <= wr_limit;
                end
                SEL_HVOFS: hv_ofs_q <= cfg_wdata;
                SEL_RMOFS: rm_ofs_q <= cfg_wdata;
                default: ;
            endcase
        end
    end

    rmode_route #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_route (
        .ea         (req_ea),
        .kind       (kind_e'(req_kind)),
        .ir         (req_ir),
        .dr         (req_dr),
        .hv         (req_hv),
        .hv_present (req_hv_present),
        .vrm_en     (ctrl_q[CTRL_VRM_BIT]),
        .desc_ok    (ctrl_q[CTRL_DESC_BIT]),
        .limit      (limit_q),
        .hv_ofs     (hv_ofs_q),
        .rm_ofs     (rm_ofs_q),
        .result     (nx_result),
        .addr       (nx_addr),
        .status     (nx_status),
        .fault_ea   (nx_fault_ea)
    );

    // Accept when the response slot is empty or being drained.
    always_comb req_ready = !rsp_valid || rsp_ready;
    always_comb accept    = req_valid && req_ready;

    // Register the response of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_result   <= '0;
            rsp_addr     <= '0;
            rsp_status   <= '0;
            rsp_fault_ea <= '0;
        end else if (accept) begin
            rsp_valid    <= 1'b1;
            rsp_result   <= nx_result;
            rsp_addr     <= nx_addr;
            rsp_status   <= nx_status;
            rsp_fault_ea <= nx_fault_ea;
        end else if (rsp_ready) begin
            rsp_valid    <= 1'b0;
        end
    end
endmodule

// File: rtl/rmode_xlate_chk.sv
// Protocol and response-coding checks for rmode_xlate, bound to every instance.
// Assumes req_kind never carries code 3.
module rmode_xlate_chk #(
    parameter int ADDR_W = 64,
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [2:0]        rsp_result,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [STAT_W-1:0] rsp_status,
    input logic [ADDR_W-1:0] rsp_fault_ea
);
    assert_accept_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_result)
            && $stable(rsp_addr) && $stable(rsp_status) && $stable(rsp_fault_ea));

    assert_stall_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !req_ready);

    assert_ifault_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_result == 3'd1 |-> rsp_status == 32'h0800_0000 && rsp_fault_ea == '0);

    assert_dfault_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_result == 3'd2 |->
            rsp_status == 32'h0800_0000 || rsp_status == 32'h0A00_0000);

    assert_mcheck_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_result == 3'd3 |-> rsp_status == '0 && rsp_fault_ea == '0);

    assert_ok_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_result == 3'd0 || rsp_result == 3'd4 || rsp_result == 3'd5)
            |-> rsp_status == '0 && rsp_fault_ea == '0);

    assert_reloc_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_result == 3'd5 |-> rsp_addr == '0);
endmodule

bind rmode_xlate rmode_xlate_chk #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_result   (rsp_result),
    .rsp_addr     (rsp_addr),
    .rsp_status   (rsp_status),
    .rsp_fault_ea (rsp_fault_ea)
);

// File: tb/test_rmode_xlate.sv
// Directed bench for rmode_xlate: one task per scenario.
module test_rmode_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [63:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_ea = '0;
    logic [1:0]  req_kind = '0;
    logic        req_ir = 1'b0, req_dr = 1'b0, req_hv = 1'b0, req_hv_present = 1'b1;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [2:0]  rsp_result;
    logic [63:0] rsp_addr;
    logic [31:0] rsp_status;
    logic [63:0] rsp_fault_ea;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rmode_xlate i_rmode_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea), .req_kind(req_kind),
        .req_ir(req_ir), .req_dr(req_dr), .req_hv(req_hv), .req_hv_present(req_hv_present),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_result(rsp_result),
        .rsp_addr(rsp_addr), .rsp_status(rsp_status), .rsp_fault_ea(rsp_fault_ea)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [63:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Issue one request, then sample the response one falling edge later.
    task automatic issue(input logic [63:0] ea, input logic [1:0] kind,
                         input logic ir, input logic dr, input logic hv, input logic hvp);
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_kind = kind;
        req_ir = ir; req_dr = dr; req_hv = hv; req_hv_present = hvp;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic [2:0] res, input logic [63:0] addr,
                              input logic [31:0] st, input logic [63:0] fea);
        check({tag, " valid"},  {63'd0, rsp_valid}, 64'd1);
        check({tag, " result"}, {61'd0, rsp_result}, {61'd0, res});
        check({tag, " addr"},   rsp_addr, addr);
        check({tag, " status"}, {32'd0, rsp_status}, {32'd0, st});
        check({tag, " fea"},    rsp_fault_ea, fea);
    endtask

    function automatic logic [63:0] lim_of(input int code);
        case (code)
            8: return 64'd1 << 25;
            3: return 64'd1 << 26;
            7: return 64'd1 << 27;
            4: return 64'd1 << 28;
            2: return 64'd1 << 30;
            1: return 64'd1 << 34;
            default: return 64'd0;
        endcase
    endfunction

    task automatic t_reset();
        check("R9 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R9 reset req_ready", {63'd0, req_ready}, 64'd1);
    endtask

    task automatic t_reloc();
        issue(64'h1234, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1);
        expect_rsp("R1 fetch ir on", 3'd5, 0, 0, 0);
        issue(64'h1234, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1);
        expect_rsp("R1 load dr on", 3'd5, 0, 0, 0);
        issue(64'h1234, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1);
        expect_rsp("R1 fetch ir off", 3'd0, 64'h1234, 0, 0);
    endtask

    task automatic t_hv();
        cfg(2'd1, 64'h0000_1000_0000_0000);
        issue(64'h7234_0000_0000_5678, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_rsp("R3 R2 hv bit63 clear", 3'd0, 64'h0234_1000_0000_5678, 0, 0);
        issue(64'hF234_0000_0000_5678, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_rsp("R3 hv bit63 set", 3'd0, 64'h0234_0000_0000_5678, 0, 0);
        issue(64'h0000_0000_0000_0040, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rsp("R3 no hv mode", 3'd0, 64'h0000_1000_0000_0040, 0, 0);
    endtask

    task automatic t_bounded();
        cfg(2'd2, 64'h0000_0040_0000_0000);
        issue(64'h1234, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_rsp("R5 low load", 3'd0, 64'h0000_0040_0000_1234, 0, 0);
        issue(64'h3_FFFF_FFFF, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_rsp("R5 limit-1 store", 3'd0, 64'h0000_0043_FFFF_FFFF, 0, 0);
        issue(64'hF000_0000_0000_1000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_rsp("R2 top bits dropped", 3'd0, 64'h0000_0040_0000_1000, 0, 0);
        issue(64'h4_0000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_rsp("R6 load at limit", 3'd2, 0, 32'h0800_0000, 64'h4_0000_0000);
        issue(64'h4_0000_0010, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_rsp("R6 store over", 3'd2, 0, 32'h0A00_0000, 64'h4_0000_0010);
        issue(64'h4_0000_0020, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_rsp("R6 fetch over", 3'd1, 0, 32'h0800_0000, 0);
    endtask

    task automatic t_decode();
        for (int c = 0; c < 16; c++) begin
            logic [63:0] lim;
            lim = lim_of(c);
            cfg(2'd0, 64'(c) << 8);
            if (lim != 0) begin
                issue(lim - 1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
                check($sformatf("R7 code %0d below", c), {61'd0, rsp_result}, 64'd0);
            end
            issue(lim, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
            check($sformatf("R7 R8 code %0d at limit", c), {61'd0, rsp_result}, 64'd2);
        end
    endtask

    task automatic t_vrm();
        cfg(2'd0, 64'h0000_0000_0000_0101);
        issue(64'h5000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_rsp("R4 bad descriptor", 3'd3, 0, 0, 0);
        cfg(2'd0, 64'h0000_0000_0000_0103);
        issue(64'hA000_0000_0000_5000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_rsp("R4 handoff", 3'd4, 64'h5000, 0, 0);
    endtask

    task automatic t_same_cycle();
        cfg(2'd0, 64'h100);
        @(negedge clk);
        req_valid = 1'b1; req_ea = 64'h3000_0000; req_kind = 2'd0;
        req_ir = 1'b0; req_dr = 1'b0; req_hv = 1'b0; req_hv_present = 1'b1;
        cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = 64'h400;
        @(negedge clk);
        req_valid = 1'b0; cfg_wr = 1'b0;
        check("R10 same-cycle uses old limit", {61'd0, rsp_result}, 64'd0);
        issue(64'h3000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R10 next uses new limit", {61'd0, rsp_result}, 64'd2);
    endtask

    task automatic t_stall();
        logic [63:0] held;
        rsp_ready = 1'b0;
        issue(64'h1_0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        held = rsp_addr;
        @(negedge clk);
        req_valid = 1'b1; req_ea = 64'h2_0000;
        check("R9 ready low when stalled", {63'd0, req_ready}, 64'd0);
        repeat (3) @(negedge clk);
        check("R9 held addr", rsp_addr, held);
        check("R9 held valid", {63'd0, rsp_valid}, 64'd1);
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 second after release", rsp_addr, 64'h0000_1000_0002_0000);
        @(negedge clk);
        check("R9 drained", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_reset_limit();
        cfg(2'd0, 64'h800);
        do_reset();
        issue(64'h3_0000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 reset restores 16GB", {61'd0, rsp_result}, 64'd0);
        check("R8 reset clears offset", rsp_addr, 64'h3_0000_0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_reloc();
        t_hv();
        t_bounded();
        t_decode();
        t_vrm();
        t_same_cycle();
        t_stall();
        t_reset_limit();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule